// File: doc/BRIEF.md
# Display Controller Interrupt Status and Enable Unit

This block collects single-cycle event pulses from a display controller and reports them to a host on one interrupt line. The events are: sync lost, FIFO underflow, palette load done, end of frame for buffer 0, and end of frame for buffer 1. Every event is latched in a raw status register whether or not its source is enabled. A per-source enable mask selects which latched events count toward the interrupt. The host changes the mask only through two write-only strobes, one that sets bits and one that clears them. The host clears status bits by writing ones to them.

The interrupt line gives one single-cycle pulse and then stays quiet. It stays quiet until the host writes the end-of-interrupt register, which re-arms it. If enabled status is still pending when the block is re-armed, it pulses again. Register writes come in on a simple one-cycle write strobe with address and data. Reads are combinational from the address. An asynchronous active-low reset is released into the block through a two-stage synchronizer.

Top module: `lcd_irq_ctrl`

## Requirements
- R1: During reset and after it, every status and enable bit is zero, the interrupt output is low, and every register reads zero.
- R2: An event pulse sets its raw status bit (read at offset 0x58) at the edge that samples it, whether or not the source is enabled. Bit positions: sync lost 2, underflow 5, palette done 6, end of frame 0 at 8, end of frame 1 at 9. Bit 0 of the event input is sync lost, bit 1 underflow, bit 2 palette done, bit 3 end of frame 0, bit 4 end of frame 1.
- R3: A write to the raw status offset 0x58 or to the masked status offset 0x5C clears each status bit written as one. Bits written as zero keep their value.
- R4: If an event arrives in the same cycle as a write that clears its status bit, the bit stays set.
- R5: A write to offset 0x60 sets each enable bit written as one; zero bits have no effect. Reading 0x60 or 0x64 returns the enable mask, at the same bit positions as the status bits.
- R6: A write to offset 0x64 clears each enable bit written as one; zero bits have no effect.
- R7: Offset 0x5C reads the raw status ANDed with the enable mask.
- R8: When the output is armed and the masked status is nonzero, the interrupt output is high for exactly one cycle, in the cycle after the status bit was latched. After that it stays low, even if new enabled events arrive.
- R9: A write of any data to offset 0x68 re-arms the output, and that offset reads zero. If the masked status is nonzero after the re-arm, the output pulses in the next cycle. If it is zero, the output stays low until an enabled event is latched.
- R10: If an end-of-interrupt write arrives in the same cycle as a pulse, the pulse wins and the output stays disarmed.
- R11: Writes to unmapped offsets change nothing. Data bits outside the five source positions are ignored. Unmapped offsets and unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | Event pulses: [0] sync lost, [1] underflow, [2] palette done, [3] end of frame 0, [4] end of frame 1 |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register byte offset, for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| irq_o | output | 1 | Interrupt pulse to the host |

## Verification
Events are driven one at a time, in pairs, and for all sources at once. Each pattern shows that every source lands on its own bit and that accumulation does not disturb bits already set. Enable writes with ones, with zeros and with all ones, through both the set and the clear offsets, tell set from clear and show that data outside the five source positions is ignored. Clears through both status offsets, and a clear that collides with an event, tell the write-one-to-clear path apart from event priority. Interrupt sequences cover several cases:
- an event on a disabled source;
- a first pulse;
- events that arrive while disarmed;
- a re-arm with nothing pending;
- a re-arm with status still pending;
- a re-arm that lands on the pulse cycle.

Together these tell the arming logic apart from a plain level OR of the masked status.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

  // Number of event sources handled by the unit.
  localparam int NUM_SRC = 5;

  // Register bit position of each source, indexed like the event input:
  // 0 sync lost, 1 underflow, 2 palette done, 3 end of frame 0, 4 end of frame 1.
  localparam int SRC_POS [NUM_SRC] = '{2, 5, 6, 8, 9};

  // Byte offsets of the register window.
  localparam int OFS_RAW = 'h58;
  localparam int OFS_MSK = 'h5C;
  localparam int OFS_SET = 'h60;
  localparam int OFS_CLR = 'h64;
  localparam int OFS_EOI = 'h68;

  // Arming state of the interrupt output.
  typedef enum logic {
    GATE_ARMED = 1'b0,
    GATE_SPENT = 1'b1
  } gate_state_e;

endpackage

// File: rtl/lcd_irq_status.sv
module lcd_irq_status #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            clr_req,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] stat
);

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_cell
    logic s_q;
    logic s_d;
    logic s_ce;

    // An event forces a one and wins over a clear in the same cycle.
    always_comb begin
      s_ce = evt[gi] | (clr_req & clr_bits[gi]);
      s_d  = evt[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s_q <= 1'b0;
      end else if (s_ce) begin
        s_q <= s_d;
      end
    end

    assign stat[gi] = s_q;
  end

endmodule

// File: rtl/lcd_irq_enable.sv
module lcd_irq_enable #(
  parameter int NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_req,
  input  logic            clr_req,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] mask
);

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] en_d;
  logic            en_ce;

  always_comb begin
    en_ce = set_req | clr_req;
    en_d  = en_q;
    if (set_req) begin
      en_d = en_d | bits;
    end
    if (clr_req) begin
      en_d = en_d & ~bits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign mask = en_q;

endmodule

// File: rtl/lcd_irq_gate.sv
module lcd_irq_gate
  import lcd_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  input  logic eoi,
  output logic irq
);

  gate_state_e state_q;
  gate_state_e state_d;
  logic        irq_q;
  logic        fire;

  // A pulse consumes the arming; end of interrupt re-arms unless a pulse
  // is leaving in the same cycle.
  always_comb begin
    fire    = (state_q == GATE_ARMED) && pending;
    state_d = state_q;
    if (fire) begin
      state_d = GATE_SPENT;
    end else if (eoi) begin
      state_d = GATE_ARMED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_ARMED;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= fire;
    end
  end

  assign irq = irq_q;

endmodule

// File: rtl/lcd_irq_ctrl.sv
module lcd_irq_ctrl
  import lcd_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o
);

  localparam int NSRC = NUM_SRC;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[1];

  // Offset decode.
  logic hit_raw, hit_msk, hit_set, hit_clr, hit_eoi;

  always_comb begin
    hit_raw = (reg_addr == ADDR_W'(OFS_RAW));
    hit_msk = (reg_addr == ADDR_W'(OFS_MSK));
    hit_set = (reg_addr == ADDR_W'(OFS_SET));
    hit_clr = (reg_addr == ADDR_W'(OFS_CLR));
    hit_eoi = (reg_addr == ADDR_W'(OFS_EOI));
  end

  // Pick the source bits out of the write data.
  logic [NSRC-1:0] wr_bits;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_pick
    assign wr_bits[gi] = reg_wdata[SRC_POS[gi]];
  end

  function automatic logic [DATA_W-1:0] spread(input logic [NSRC-1:0] b);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < NSRC; i++) begin
      w[SRC_POS[i]] = b[i];
    end
    return w;
  endfunction

  logic [NSRC-1:0] raw_stat;
  logic [NSRC-1:0] en_mask;
  logic [NSRC-1:0] masked;

  lcd_irq_status #(.NSRC(NSRC)) status_i (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .evt      (src_evt),
    .clr_req  (reg_wr & (hit_raw | hit_msk)),
    .clr_bits (wr_bits),
    .stat     (raw_stat)
  );

  lcd_irq_enable #(.NSRC(NSRC)) enable_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_req (reg_wr & hit_set),
    .clr_req (reg_wr & hit_clr),
    .bits    (wr_bits),
    .mask    (en_mask)
  );

  assign masked = raw_stat & en_mask;

  lcd_irq_gate gate_i (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .pending (|masked),
    .eoi     (reg_wr & hit_eoi),
    .irq     (irq_o)
  );

  // Read mux.
  always_comb begin
    reg_rdata = '0;
    if (hit_raw) begin
      reg_rdata = spread(raw_stat);
    end else if (hit_msk) begin
      reg_rdata = spread(masked);
    end else if (hit_set || hit_clr) begin
      reg_rdata = spread(en_mask);
    end
  end

endmodule

// File: rtl/lcd_irq_ctrl_chk.sv
module lcd_irq_ctrl_chk
  import lcd_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_evt,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NUM_SRC-1:0] raw_stat,
  input logic [NUM_SRC-1:0] en_mask,
  input logic               irq_o
);

  logic [NUM_SRC-1:0] wbits;
  logic               wr_w1c, wr_set, wr_clr, wr_unmapped;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      wbits[i] = reg_wdata[SRC_POS[i]];
    end
    wr_w1c = reg_wr && (reg_addr == ADDR_W'(OFS_RAW) || reg_addr == ADDR_W'(OFS_MSK));
    wr_set = reg_wr && (reg_addr == ADDR_W'(OFS_SET));
    wr_clr = reg_wr && (reg_addr == ADDR_W'(OFS_CLR));
    wr_unmapped = reg_wr && reg_addr != ADDR_W'(OFS_RAW) && reg_addr != ADDR_W'(OFS_MSK)
                  && reg_addr != ADDR_W'(OFS_SET) && reg_addr != ADDR_W'(OFS_CLR)
                  && reg_addr != ADDR_W'(OFS_EOI);
  end

  // R2, R4: a sampled event is always latched, even against a clear.
  a_r2_event_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_evt) |=> ((raw_stat & $past(src_evt)) == $past(src_evt)));

  // R3: ones clear the status when no event competes.
  a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w1c && src_evt == '0) |=> ((raw_stat & $past(wbits)) == '0));

  // R5
  a_r5_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en_mask & $past(wbits)) == $past(wbits)));

  // R6
  a_r6_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en_mask & $past(wbits)) == '0));

  // R8: the output is a single-cycle pulse caused by enabled status.
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  a_r8_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past((raw_stat & en_mask) != '0));

  // R11
  a_r11_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_unmapped && src_evt == '0) |=> ($stable(raw_stat) && $stable(en_mask)));

endmodule

bind lcd_irq_ctrl lcd_irq_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .src_evt   (src_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .raw_stat  (raw_stat),
  .en_mask   (en_mask),
  .irq_o     (irq_o)
);

// File: tb/lcd_irq_ctrl_tb_top.sv
module lcd_irq_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [4:0]  evt;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Walked after a fresh reset; each row is one drive cycle then one read.
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'h00, 32'h0,        5'b00001, 8'h58, 32'h004, 4'd2},  // R2 sync lost
    '{1'b0, 8'h00, 32'h0,        5'b00110, 8'h58, 32'h064, 4'd2},  // R2 underflow, palette
    '{1'b0, 8'h00, 32'h0,        5'b11000, 8'h58, 32'h364, 4'd2},  // R2 both end of frame
    '{1'b0, 8'h00, 32'h0,        5'b00000, 8'h5C, 32'h000, 4'd7},  // R7 nothing enabled
    '{1'b1, 8'h60, 32'h120,      5'b00000, 8'h60, 32'h120, 4'd5},  // R5 set
    '{1'b1, 8'h60, 32'h0,        5'b00000, 8'h64, 32'h120, 4'd5},  // R5 zeros no effect
    '{1'b0, 8'h00, 32'h0,        5'b00000, 8'h5C, 32'h120, 4'd7},  // R7 masked
    '{1'b1, 8'h64, 32'h020,      5'b00000, 8'h60, 32'h100, 4'd6},  // R6 clear
    '{1'b1, 8'h64, 32'h0,        5'b00000, 8'h60, 32'h100, 4'd6},  // R6 zeros no effect
    '{1'b1, 8'h58, 32'h004,      5'b00000, 8'h58, 32'h360, 4'd3},  // R3 via raw
    '{1'b1, 8'h5C, 32'h240,      5'b00000, 8'h58, 32'h120, 4'd3},  // R3 via masked
    '{1'b1, 8'h58, 32'h120,      5'b00010, 8'h58, 32'h020, 4'd4},  // R4 event wins
    '{1'b1, 8'h7C, 32'hFFFFFFFF, 5'b00000, 8'h58, 32'h020, 4'd11}, // R11 unmapped write
    '{1'b0, 8'h00, 32'h0,        5'b00000, 8'h60, 32'h100, 4'd11}, // R11 enables untouched
    '{1'b1, 8'h60, 32'hFFFFFFFF, 5'b00000, 8'h60, 32'h364, 4'd11}, // R11 unused bits
    '{1'b1, 8'h64, 32'hFFFFFFFF, 5'b00000, 8'h68, 32'h000, 4'd9},  // R9 eoi reads zero
    '{1'b1, 8'h58, 32'hFFFFFFFF, 5'b00000, 8'h58, 32'h000, 4'd3}   // R3 clear all
  };

  logic        clk;
  logic        rst_n;
  logic [4:0]  src_evt;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  lcd_irq_ctrl #(.ADDR_W(8), .DATA_W(32)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_evt   (src_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Called at a falling edge; drives for one rising edge, returns at the next falling edge.
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [4:0] e);
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_evt = e;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; src_evt = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic irq_quiet(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, {31'b0, irq_o}, 32'h0);
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; src_evt = '0;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic reset_state_check(input string tag);
    rd(8'h58, 32'h0, {tag, " raw"});
    rd(8'h5C, 32'h0, {tag, " masked"});
    rd(8'h60, 32'h0, {tag, " enable"});
    rd(8'h68, 32'h0, {tag, " eoi"});
    chk({tag, " irq"}, {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    reset_state_check("R1 after reset");

    // Vector walk.
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].evt);
      rd(VECS[i].raddr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // Interrupt gating, from a fresh reset.
    do_reset();
    step(1'b1, 8'h60, 32'h100, 5'b00000);            // enable end of frame 0
    step(1'b0, 8'h00, 32'h0, 5'b10000);              // disabled source fires
    rd(8'h58, 32'h200, "R2 disabled source latched");
    irq_quiet(4, "R8 disabled source no irq");

    step(1'b0, 8'h00, 32'h0, 5'b01000);              // enabled source fires
    chk("R8 irq not yet", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R8 irq pulse", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R8 pulse one cycle", {31'b0, irq_o}, 32'h0);
    step(1'b0, 8'h00, 32'h0, 5'b01000);              // more events while disarmed
    irq_quiet(5, "R8 disarmed");

    step(1'b1, 8'h58, 32'h300, 5'b00000);            // clear everything
    step(1'b1, 8'h68, 32'h0, 5'b00000);              // re-arm with nothing pending
    irq_quiet(4, "R9 rearm idle");

    step(1'b0, 8'h00, 32'h0, 5'b01000);
    chk("R9 rearmed wait", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 rearmed pulse", {31'b0, irq_o}, 32'h1);
    @(negedge clk);

    step(1'b1, 8'h68, 32'hDEAD, 5'b00000);           // re-arm with status pending
    chk("R9 pending wait", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R9 pending pulse", {31'b0, irq_o}, 32'h1);

    // R10: end of interrupt landing on the pulse cycle.
    step(1'b1, 8'h68, 32'h0, 5'b00000);              // arms
    step(1'b1, 8'h68, 32'h0, 5'b00000);              // coincides with the pulse
    chk("R10 pulse on eoi cycle", {31'b0, irq_o}, 32'h1);
    @(negedge clk);
    irq_quiet(5, "R10 stays disarmed");

    // R1: reset clears state that was built up.
    do_reset();
    reset_state_check("R1 reset after use");

    finish_run();
  end

endmodule